// File: doc/BRIEF.md
# SPI Transfer Length Sequencer

This block sequences one SPI transfer at a time. It does not shift any bits. A separate shift engine does that work and reports each finished word with a one-cycle `word_done` pulse. The sequencer decides when a transfer may begin and tells the engine to start. It counts finished words separately for the transmit and receive directions, each against its own 20-bit length. When every active direction has reached its length, it tells the engine to stop. A direction that reaches its length raises that direction's end event in a small interrupt register, which offers raw, enable-filtered and clear-on-write views.

The trigger that starts a transfer depends on the wiring mode. With four-wire wiring, `kick` starts an ordinary transfer. The exception is a receive-only transfer with four-wire wiring: no transmit data is written, so it is started by a rising start bit in a separate word. That word also carries a 9-bit count of words to receive. With three-wire or dual-line wiring, a software transmit or receive request pulse starts the transfer. The transmit-busy output covers the tail of a transfer: it stays high past the transmit end event until the engine reports that the line is idle.

Top module: `tls_xfer_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `eng_start`, `eng_stop`, `tx_busy`, `irq`, `raw_word` and `masked_word` are all zero.
- R2: The TX end event is `raw_word` bit 8. It sets on the clock edge that counts the Nth `word_done`, where N = {`tx_len_hi`,`tx_len_lo`} (hi = length bits 19:16), and not before. N is captured when the transfer launches, so later changes to the length inputs have no effect on it.
- R3: The RX end event is `raw_word` bit 9. It behaves the same way against {`rx_len_hi`,`rx_len_lo`}. When both directions are enabled, each direction counts the same `word_done` pulses against its own length.
- R4: An enabled direction with a length of zero raises its end event on the launch edge. If no enabled direction has a non-zero length, no engine start is issued.
- R5: `eng_start` is a one-cycle pulse on the launch edge. `eng_stop` is a one-cycle pulse on the edge where the last running direction reaches its length.
- R6: `tx_busy` rises at the launch of a transfer that has TX enabled with a non-zero length. It is still high in the cycle after the TX end event. It falls only on an edge where the TX count is complete and `line_idle` is high.
- R7: With four-wire wiring and RX alone enabled, a 0-to-1 change of `ro_word` bit 9 launches reception of `ro_word[8:0]` words, and the RX lengths are ignored. Holding bit 9 high does not launch again.
- R8: `line_mode` is encoded as 00 for four-wire, 01 for three-wire, and 10 or 11 for dual-line. In four-wire mode, `kick` launches any transfer except receive-only. In the other modes, `sw_tx_req` launches when TX is enabled and `sw_rx_req` launches when RX alone is enabled. Every other trigger is ignored.
- R9: TX is enabled by `mode_word` bit 13 and RX by bit 12. Clearing both bits aborts a transfer in progress: counting stops, `tx_busy` falls, no end event is raised, and `eng_stop` pulses if the engine was running.
- R10: Writing `clr_word` with `clr_we` high clears each raw bit whose matching bit (8 or 9) is one. An end event on the same edge wins over the clear.
- R11: `masked_word` equals `raw_word` AND `int_en_word`, using the same bit positions 8 and 9. `irq` is the OR of the `masked_word` bits.
- R12: `word_done` is ignored when no transfer is running. Launch triggers are ignored while a transfer or its drain is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_word | input | 16 | Direction enables: bit 13 TX, bit 12 RX |
| line_mode | input | 2 | Wiring mode: 00 four-wire, 01 three-wire, 1x dual-line |
| tx_len_hi | input | 4 | TX length bits 19:16 |
| tx_len_lo | input | 16 | TX length bits 15:0 |
| rx_len_hi | input | 4 | RX length bits 19:16 |
| rx_len_lo | input | 16 | RX length bits 15:0 |
| ro_word | input | 16 | Receive-only word: bits 8:0 count, bit 9 start |
| kick | input | 1 | Launch trigger for four-wire transfers |
| sw_tx_req | input | 1 | Software transmit request (three-wire or dual-line) |
| sw_rx_req | input | 1 | Software receive request (three-wire or dual-line) |
| word_done | input | 1 | Shift engine finished one word |
| line_idle | input | 1 | Shift engine has fully stopped shifting |
| int_en_word | input | 16 | Event enables: bit 8 TX end, bit 9 RX end |
| clr_we | input | 1 | Strobe that applies `clr_word` |
| clr_word | input | 16 | Write-one-to-clear word, same bit positions as the events |
| eng_start | output | 1 | One-cycle start pulse to the shift engine |
| eng_stop | output | 1 | One-cycle stop pulse to the shift engine |
| tx_busy | output | 1 | Transmit still in progress or draining |
| raw_word | output | 16 | Raw event status (bits 8 and 9) |
| masked_word | output | 16 | Raw status filtered by the enables |
| irq | output | 1 | OR of the masked status bits |

## Verification
A wrong word count shows up at the ports straight away. The end event appears one edge early or one edge late against the Nth `word_done` pulse, and `eng_stop` moves with it. The bench therefore compares both against lengths computed arithmetically, after every single pulse. A wrong launch or drain state shows up as a missing or repeated `eng_start`, or as `tx_busy` falling before `line_idle`, and is visible in the first cycle after the faulty edge. A lost or stuck raw bit shows up on `irq` within one cycle of the enable or clear write.

// File: rtl/tls_pkg.sv
package tls_pkg;

    localparam int NLANE    = 2;
    localparam int LANE_TX  = 0;
    localparam int LANE_RX  = 1;

    localparam int MODE_TX_BIT = 13;
    localparam int MODE_RX_BIT = 12;
    localparam int EVT_TX_BIT  = 8;
    localparam int EVT_RX_BIT  = 9;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_DRAIN  = 2'd2
    } seq_state_t;

    localparam logic [1:0] LM_FOUR  = 2'b00;
    localparam logic [1:0] LM_THREE = 2'b01;

    function automatic int evt_pos(input int lane);
        return (lane == LANE_TX) ? EVT_TX_BIT : EVT_RX_BIT;
    endfunction

endpackage

// File: rtl/tls_lane_counter.sv
module tls_lane_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             abort,
    input  logic             active,
    input  logic [CNT_W-1:0] target,
    input  logic             word_pulse,
    output logic             running,
    output logic             end_hit
);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] tgt;
    } lane_t;

    lane_t lane_q, lane_d;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        lane_d  = lane_q;
        end_hit = 1'b0;
        cnt_inc = lane_q.cnt + 1'b1;
        if (abort) begin
            lane_d.run = 1'b0;
            lane_d.cnt = '0;
        end else if (load) begin
            lane_d.cnt = '0;
            lane_d.tgt = target;
            lane_d.run = 1'b0;
            if (active) begin
                if (target == '0) begin
                    end_hit = 1'b1;
                end else begin
                    lane_d.run = 1'b1;
                end
            end
        end else if (lane_q.run && word_pulse) begin
            lane_d.cnt = cnt_inc;
            if (cnt_inc == lane_q.tgt) begin
                lane_d.run = 1'b0;
                end_hit    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign running = lane_q.run;

endmodule

// File: rtl/tls_launch_decode.sv
module tls_launch_decode (
    input  logic       tx_on,
    input  logic       rx_on,
    input  logic [1:0] line_mode,
    input  logic       kick,
    input  logic       sw_tx_req,
    input  logic       sw_rx_req,
    input  logic       ro_rise,
    output logic       launch,
    output logic       ro_sel
);
    import tls_pkg::*;

    always_comb begin
        launch = 1'b0;
        ro_sel = 1'b0;
        if (tx_on || rx_on) begin
            if (line_mode == LM_FOUR) begin
                if (rx_on && !tx_on) begin
                    launch = ro_rise;
                    ro_sel = 1'b1;
                end else begin
                    launch = kick;
                end
            end else if (tx_on) begin
                launch = sw_tx_req;
            end else begin
                launch = sw_rx_req;
            end
        end
    end

endmodule

// File: rtl/tls_event_regs.sv
module tls_event_regs #(
    parameter int REG_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [tls_pkg::NLANE-1:0] hit,
    input  logic                     clr_we,
    input  logic [REG_W-1:0]         clr_word,
    input  logic [REG_W-1:0]         en_word,
    output logic [REG_W-1:0]         raw_word,
    output logic [REG_W-1:0]         masked_word,
    output logic                     irq
);
    import tls_pkg::*;

    typedef struct packed {
        logic [NLANE-1:0] raw;
    } evt_t;

    evt_t evt_q, evt_d;
    logic [NLANE-1:0] en_bits;
    logic [NLANE-1:0] msk_bits;
    logic             unused_evt;

    always_comb begin
        evt_d = evt_q;
        for (int i = 0; i < NLANE; i++) begin
            if (hit[i]) begin
                evt_d.raw[i] = 1'b1;
            end else if (clr_we && clr_word[evt_pos(i)]) begin
                evt_d.raw[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
        end
    end

    always_comb begin
        raw_word    = '0;
        masked_word = '0;
        for (int i = 0; i < NLANE; i++) begin
            en_bits[i]             = en_word[evt_pos(i)];
            msk_bits[i]            = evt_q.raw[i] & en_bits[i];
            raw_word[evt_pos(i)]    = evt_q.raw[i];
            masked_word[evt_pos(i)] = msk_bits[i];
        end
    end

    assign irq = |msk_bits;

    assign unused_evt = ^{clr_word, en_word};

endmodule

// File: rtl/tls_xfer_seq.sv
module tls_xfer_seq #(
    parameter int LEN_W = 20,
    parameter int LO_W  = 16,
    parameter int RO_W  = 9,
    parameter int REG_W = 16,
    localparam int HI_W = LEN_W - LO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] mode_word,
    input  logic [1:0]       line_mode,
    input  logic [HI_W-1:0]  tx_len_hi,
    input  logic [LO_W-1:0]  tx_len_lo,
    input  logic [HI_W-1:0]  rx_len_hi,
    input  logic [LO_W-1:0]  rx_len_lo,
    input  logic [REG_W-1:0] ro_word,
    input  logic             kick,
    input  logic             sw_tx_req,
    input  logic             sw_rx_req,
    input  logic             word_done,
    input  logic             line_idle,
    input  logic [REG_W-1:0] int_en_word,
    input  logic             clr_we,
    input  logic [REG_W-1:0] clr_word,
    output logic             eng_start,
    output logic             eng_stop,
    output logic             tx_busy,
    output logic [REG_W-1:0] raw_word,
    output logic [REG_W-1:0] masked_word,
    output logic             irq
);
    import tls_pkg::*;

    typedef struct packed {
        seq_state_t state;
        logic       start;
        logic       stop;
        logic       tx_busy;
        logic       ro_arm;
    } seq_t;

    seq_t seq_q, seq_d;

    logic             tx_on, rx_on, abort;
    logic             ro_rise, launch_req, ro_sel, launch_ok;
    logic             lanes_left, any_nz;
    logic [NLANE-1:0] lane_run, lane_hit, lane_act, lane_nz;
    logic [LEN_W-1:0] lane_tgt [NLANE];
    logic             unused_top;

    assign tx_on   = mode_word[MODE_TX_BIT];
    assign rx_on   = mode_word[MODE_RX_BIT];
    assign abort   = !tx_on && !rx_on;
    assign ro_rise = ro_word[RO_W] && !seq_q.ro_arm;

    tls_launch_decode u_launch (
        .tx_on     (tx_on),
        .rx_on     (rx_on),
        .line_mode (line_mode),
        .kick      (kick),
        .sw_tx_req (sw_tx_req),
        .sw_rx_req (sw_rx_req),
        .ro_rise   (ro_rise),
        .launch    (launch_req),
        .ro_sel    (ro_sel)
    );

    assign launch_ok = launch_req && (seq_q.state == ST_IDLE);

    assign lane_tgt[LANE_TX] = {tx_len_hi, tx_len_lo};
    assign lane_tgt[LANE_RX] = ro_sel ? {{(LEN_W-RO_W){1'b0}}, ro_word[RO_W-1:0]}
                                      : {rx_len_hi, rx_len_lo};
    assign lane_act[LANE_TX] = tx_on;
    assign lane_act[LANE_RX] = rx_on;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lane_nz[g] = lane_act[g] && (lane_tgt[g] != '0);

        tls_lane_counter #(
            .CNT_W (LEN_W)
        ) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (launch_ok),
            .abort      (abort),
            .active     (lane_act[g]),
            .target     (lane_tgt[g]),
            .word_pulse (word_done),
            .running    (lane_run[g]),
            .end_hit    (lane_hit[g])
        );
    end

    assign any_nz     = |lane_nz;
    assign lanes_left = |(lane_run & ~lane_hit);

    always_comb begin
        seq_d        = seq_q;
        seq_d.start  = 1'b0;
        seq_d.stop   = 1'b0;
        seq_d.ro_arm = ro_word[RO_W];
        if (abort) begin
            seq_d.state   = ST_IDLE;
            seq_d.tx_busy = 1'b0;
            seq_d.stop    = (seq_q.state == ST_ACTIVE);
        end else begin
            if (seq_q.tx_busy && !lane_run[LANE_TX] && line_idle) begin
                seq_d.tx_busy = 1'b0;
            end
            case (seq_q.state)
                ST_IDLE: begin
                    if (launch_ok && any_nz) begin
                        seq_d.state   = ST_ACTIVE;
                        seq_d.start   = 1'b1;
                        seq_d.tx_busy = lane_nz[LANE_TX];
                    end
                end
                ST_ACTIVE: begin
                    if ((|lane_hit) && !lanes_left) begin
                        seq_d.stop  = 1'b1;
                        seq_d.state = seq_d.tx_busy ? ST_DRAIN : ST_IDLE;
                    end
                end
                ST_DRAIN: begin
                    if (!seq_d.tx_busy) begin
                        seq_d.state = ST_IDLE;
                    end
                end
                default: seq_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, start: 1'b0, stop: 1'b0, tx_busy: 1'b0, ro_arm: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    tls_event_regs #(
        .REG_W (REG_W)
    ) u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (lane_hit),
        .clr_we      (clr_we),
        .clr_word    (clr_word),
        .en_word     (int_en_word),
        .raw_word    (raw_word),
        .masked_word (masked_word),
        .irq         (irq)
    );

    assign eng_start = seq_q.start;
    assign eng_stop  = seq_q.stop;
    assign tx_busy   = seq_q.tx_busy;

    assign unused_top = ^{mode_word, ro_word};

endmodule

// File: rtl/tls_xfer_seq_chk.sv
module tls_xfer_seq_chk #(
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] mode_word,
    input logic             line_idle,
    input logic             clr_we,
    input logic [REG_W-1:0] clr_word,
    input logic             eng_start,
    input logic             eng_stop,
    input logic             tx_busy,
    input logic [REG_W-1:0] raw_word,
    input logic [1:0]       lane_hit
);

    logic mode_any;
    logic unused_chk;

    assign mode_any   = mode_word[13] | mode_word[12];
    assign unused_chk = ^{mode_word, clr_word, raw_word};

    // R6: busy cannot drop while the line is still shifting and no abort is applied
    assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !line_idle && mode_any) |=> tx_busy);

    // R2: the TX end bit rises only after a counted TX end hit
    assert_tx_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_word[8] |=> (!raw_word[8] || $past(lane_hit[0])));

    // R3: the RX end bit rises only after a counted RX end hit
    assert_rx_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_word[9] |=> (!raw_word[9] || $past(lane_hit[1])));

    // R10: a clear with no competing event empties the bit
    assert_tx_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_word[8] && !lane_hit[0]) |=> !raw_word[8]);

    assert_rx_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_word[9] && !lane_hit[1]) |=> !raw_word[9]);

    // R5: start is a single-cycle pulse and never coincides with stop
    assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    assert_start_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_start && eng_stop));

endmodule

bind tls_xfer_seq tls_xfer_seq_chk #(.REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_word (mode_word),
    .line_idle (line_idle),
    .clr_we    (clr_we),
    .clr_word  (clr_word),
    .eng_start (eng_start),
    .eng_stop  (eng_stop),
    .tx_busy   (tx_busy),
    .raw_word  (raw_word),
    .lane_hit  (lane_hit)
);

// File: tb/tb_tls_xfer_seq.sv
module tb_tls_xfer_seq;

    logic        clk;
    logic        rst_n;
    logic [15:0] mode_word;
    logic [1:0]  line_mode;
    logic [3:0]  tx_len_hi, rx_len_hi;
    logic [15:0] tx_len_lo, rx_len_lo;
    logic [15:0] ro_word;
    logic        kick, sw_tx_req, sw_rx_req, word_done, line_idle;
    logic [15:0] int_en_word;
    logic        clr_we;
    logic [15:0] clr_word;
    logic        eng_start, eng_stop, tx_busy, irq;
    logic [15:0] raw_word, masked_word;

    int n_chk  = 0;
    int n_fail = 0;

    tls_xfer_seq dut (
        .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .line_mode(line_mode),
        .tx_len_hi(tx_len_hi), .tx_len_lo(tx_len_lo),
        .rx_len_hi(rx_len_hi), .rx_len_lo(rx_len_lo),
        .ro_word(ro_word), .kick(kick), .sw_tx_req(sw_tx_req), .sw_rx_req(sw_rx_req),
        .word_done(word_done), .line_idle(line_idle), .int_en_word(int_en_word),
        .clr_we(clr_we), .clr_word(clr_word),
        .eng_start(eng_start), .eng_stop(eng_stop), .tx_busy(tx_busy),
        .raw_word(raw_word), .masked_word(masked_word), .irq(irq)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_job(input bit tx, input bit rx, input int a, input int b);
        mode_word     = 16'h0;
        mode_word[13] = tx;
        mode_word[12] = rx;
        tx_len_lo = a[15:0];
        tx_len_hi = a[19:16];
        rx_len_lo = b[15:0];
        rx_len_hi = b[19:16];
    endtask

    task automatic clear_all();
        clr_we   = 1'b1;
        clr_word = 16'h0300;
        tick();
        clr_we   = 1'b0;
        clr_word = 16'h0;
    endtask

    // four-wire transfer with per-pulse expectations
    task automatic run_fw(input bit tx, input bit rx, input int a, input int b);
        int  n;
        bit  go;
        set_job(tx, rx, a, b);
        kick = 1'b1;
        tick();
        kick = 1'b0;
        go = (tx && a > 0) || (rx && b > 0);
        chk("R5", "eng_start at launch", int'(eng_start), int'(go));
        chk("R4", "tx end at launch", int'(raw_word[8]), int'(tx && a == 0));
        chk("R4", "rx end at launch", int'(raw_word[9]), int'(rx && b == 0));
        n = 0;
        if (tx && a > n) n = a;
        if (rx && b > n) n = b;
        word_done = (n > 0);
        for (int k = 1; k <= n; k++) begin
            tick();
            if (k == n) word_done = 1'b0;
            chk("R2", "tx end vs count", int'(raw_word[8]), int'(tx && k >= a));
            chk("R3", "rx end vs count", int'(raw_word[9]), int'(rx && k >= b));
            chk("R5", "eng_stop timing", int'(eng_stop), int'(k == n));
            chk("R6", "tx_busy during run", int'(tx_busy), int'(tx && a > 0 && k <= a));
        end
        tick();
        tick();
        chk("R6", "tx_busy after drain", int'(tx_busy), 0);
        clear_all();
        chk("R10", "raw after clear", int'(raw_word), 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        mode_word = 16'h0; line_mode = 2'b00;
        tx_len_hi = 4'h0; tx_len_lo = 16'h0; rx_len_hi = 4'h0; rx_len_lo = 16'h0;
        ro_word = 16'h0; kick = 1'b0; sw_tx_req = 1'b0; sw_rx_req = 1'b0;
        word_done = 1'b0; line_idle = 1'b1; int_en_word = 16'h0;
        clr_we = 1'b0; clr_word = 16'h0;
        tick();
        tick();
        chk("R1", "eng_start in reset", int'(eng_start), 0);
        chk("R1", "tx_busy in reset", int'(tx_busy), 0);
        chk("R1", "raw in reset", int'(raw_word), 0);
        rst_n = 1'b1;
        tick();
        chk("R1", "stop after reset", int'(eng_stop), 0);
        chk("R1", "irq after reset", int'(irq), 0);
        chk("R1", "masked after reset", int'(masked_word), 0);

        // R12: word pulses with no transfer are ignored
        set_job(1, 0, 1, 0);
        word_done = 1'b1;
        repeat (5) tick();
        word_done = 1'b0;
        tick();
        chk("R12", "idle word_done no end", int'(raw_word), 0);
        chk("R12", "idle word_done no stop", int'(eng_stop), 0);

        // R2: transmit-only length sweep
        for (int a = 0; a <= 6; a++) run_fw(1, 0, a, 0);
        // R3: full-duplex sweep over both lengths
        for (int a = 0; a <= 4; a++)
            for (int b = 0; b <= 4; b++)
                run_fw(1, 1, a, b);

        // R11: mask and irq over every enable pattern
        set_job(1, 1, 0, 0);
        kick = 1'b1;
        tick();
        kick = 1'b0;
        for (int e = 0; e < 4; e++) begin
            int_en_word = 16'(e << 8);
            #1;
            chk("R11", "masked word", int'(masked_word), e << 8);
            chk("R11", "irq", int'(irq), int'(e != 0));
            tick();
        end
        int_en_word = 16'h0;
        clear_all();

        // R10: event beats a same-edge clear; clear is per bit
        set_job(1, 0, 0, 0);
        kick = 1'b1; clr_we = 1'b1; clr_word = 16'h0100;
        tick();
        kick = 1'b0; clr_we = 1'b0; clr_word = 16'h0;
        chk("R10", "set wins over clear", int'(raw_word[8]), 1);
        clr_we = 1'b1; clr_word = 16'h0200;
        tick();
        clr_we = 1'b0; clr_word = 16'h0;
        chk("R10", "other bit clear keeps tx", int'(raw_word[8]), 1);
        clr_we = 1'b1; clr_word = 16'h0100;
        tick();
        clr_we = 1'b0; clr_word = 16'h0;
        chk("R10", "tx bit cleared", int'(raw_word[8]), 0);

        // R2: length captured at launch
        set_job(1, 0, 3, 0);
        kick = 1'b1;
        tick();
        kick = 1'b0;
        tx_len_lo = 16'd1;
        word_done = 1'b1;
        tick();
        word_done = 1'b0;
        chk("R2", "changed length ignored", int'(raw_word[8]), 0);
        // R12: kick during a running transfer is ignored
        kick = 1'b1;
        tick();
        kick = 1'b0;
        chk("R12", "kick while active", int'(eng_start), 0);
        word_done = 1'b1;
        tick();
        chk("R12", "count not restarted", int'(raw_word[8]), 0);
        tick();
        word_done = 1'b0;
        chk("R2", "captured length reached", int'(raw_word[8]), 1);
        tick(); tick();
        clear_all();

        // R2 and R9: high field counts, then abort
        set_job(1, 0, 32'h10002, 0);
        kick = 1'b1;
        tick();
        kick = 1'b0;
        word_done = 1'b1;
        repeat (4) tick();
        word_done = 1'b0;
        chk("R2", "high field extends length", int'(raw_word[8]), 0);
        chk("R6", "busy while long run", int'(tx_busy), 1);
        mode_word = 16'h0;
        tick();
        chk("R9", "abort stop pulse", int'(eng_stop), 1);
        chk("R9", "abort drops busy", int'(tx_busy), 0);
        chk("R9", "abort no event", int'(raw_word), 0);
        tick();
        chk("R9", "stop is one pulse", int'(eng_stop), 0);

        // R6: drain waits for line_idle; R12 kick during drain ignored
        line_idle = 1'b0;
        set_job(1, 0, 2, 0);
        kick = 1'b1;
        tick();
        kick = 1'b0;
        word_done = 1'b1;
        tick();
        tick();
        word_done = 1'b0;
        chk("R5", "stop at tx end", int'(eng_stop), 1);
        chk("R6", "busy at tx end", int'(tx_busy), 1);
        repeat (3) tick();
        chk("R6", "busy while line active", int'(tx_busy), 1);
        kick = 1'b1;
        tick();
        kick = 1'b0;
        chk("R12", "kick during drain", int'(eng_start), 0);
        line_idle = 1'b1;
        tick();
        chk("R6", "busy falls after idle", int'(tx_busy), 0);
        clear_all();

        // R8: kick ignored for receive-only four-wire
        set_job(0, 1, 0, 7);
        ro_word = 16'h0;
        kick = 1'b1;
        tick();
        kick = 1'b0;
        chk("R8", "kick ignored rx-only", int'(eng_start), 0);
        chk("R8", "no rx event from kick", int'(raw_word[9]), 0);

        // R7: receive-only count sweep
        for (int c = 0; c <= 5; c++) begin
            ro_word = 16'(c);
            tick();
            ro_word = 16'(c) | 16'h0200;
            tick();
            chk("R7", "ro start", int'(eng_start), int'(c > 0));
            chk("R7", "ro zero count end", int'(raw_word[9]), int'(c == 0));
            word_done = (c > 0);
            for (int k = 1; k <= c; k++) begin
                tick();
                if (k == c) word_done = 1'b0;
                chk("R7", "ro end vs count", int'(raw_word[9]), int'(k >= c));
            end
            for (int w = 0; w < 3; w++) begin
                tick();
                chk("R7", "held start no relaunch", int'(eng_start), 0);
            end
            ro_word = 16'(c);
            clear_all();
        end
        ro_word = 16'h0;

        // R8: three-wire needs the software transmit request
        line_mode = 2'b01;
        set_job(1, 0, 2, 0);
        kick = 1'b1;
        tick();
        kick = 1'b0;
        chk("R8", "kick ignored three-wire", int'(eng_start), 0);
        sw_rx_req = 1'b1;
        tick();
        sw_rx_req = 1'b0;
        chk("R8", "rx req ignored in tx mode", int'(eng_start), 0);
        sw_tx_req = 1'b1;
        tick();
        sw_tx_req = 1'b0;
        chk("R8", "tx req launches", int'(eng_start), 1);
        word_done = 1'b1;
        tick(); tick();
        word_done = 1'b0;
        chk("R8", "three-wire tx end", int'(raw_word[8]), 1);
        tick(); tick();
        clear_all();

        // R8: dual-line receive uses the software receive request
        line_mode = 2'b10;
        set_job(0, 1, 0, 3);
        sw_tx_req = 1'b1;
        tick();
        sw_tx_req = 1'b0;
        chk("R8", "tx req ignored rx-only", int'(eng_start), 0);
        sw_rx_req = 1'b1;
        tick();
        sw_rx_req = 1'b0;
        chk("R8", "rx req launches", int'(eng_start), 1);
        word_done = 1'b1;
        tick(); tick();
        chk("R3", "dual rx not yet", int'(raw_word[9]), 0);
        tick();
        word_done = 1'b0;
        chk("R3", "dual rx end", int'(raw_word[9]), 1);
        chk("R6", "no busy for rx", int'(tx_busy), 0);
        tick();
        clear_all();

        finish_run();
    end

endmodule